// File: doc/BRIEF.md
# Immediate OR Execute Unit

This unit carries out the OR-with-immediate operation inside a small processor datapath. It owns the 16-bit status register. A one-cycle `start` strobe selects one of three targets.

- **General operand:** the immediate is merged into a destination value at byte, word or long size. The merged value comes back on `result`, and the condition flags are updated.
- **Condition-code byte:** the immediate sets individual flag bits.
- **Whole status register:** this is a privileged operation. It is performed only when the supervisor bit is set. Otherwise a trap request is raised and nothing is written.

Decode, operand fetch, write-back through addressing modes and exception vectoring all belong to neighbouring blocks. A separate load port lets other instructions write the status register directly.

All results are registered. The cycle after `start` shows `done` together with the new `result`, `sr_out` and `trap`.

Top module: `ori_exec_unit`

## Requirements
- R1: A general operation (target 2'b00, or 2'b11, which acts the same) returns the OR of `imm` and `dst` over the selected size. Size 2'b00 is byte, 2'b01 is word, and 2'b10 or 2'b11 is long. For byte and word sizes, the `dst` bits above the size are passed through unchanged.
- R2: After a general operation, status bit 3 (negative) equals the most significant bit of the result at the selected size.
- R3: After a general operation, status bit 2 (zero) is 1 exactly when every result bit within the selected size is 0.
- R4: A general operation clears status bits 1 (overflow) and 0 (carry), and keeps bit 4 (extend) and every status bit above bit 4.
- R5: A condition-code operation (target 2'b01) ORs `imm[4:0]` into status bits 4..0 and leaves all other status bits unchanged, so bits 7..5 stay 0. `result` then shows the new status register, zero-extended.
- R6: A status-register operation (target 2'b10) with supervisor bit 13 at 1 ORs `imm[15:0]` into the status register, limited to the implemented bits. ORing 0x8000 sets trace bit 15. `result` then shows the new status register, zero-extended.
- R7: A status-register operation with bit 13 at 0 raises `trap` for exactly one cycle, together with `done`. The status register and `result` keep their previous values.
- R8: `done` is high for exactly the one cycle after each `start` cycle, and is low otherwise.
- R9: Only status bits 15, 13, 10..8 and 4..0 (mask 0xA71F) are implemented. Every other status bit always reads 0.
- R10: After reset, `sr_out` is 0x2700, `result` is 0, and `done` and `trap` are 0.
- R11: When `start` is low, `sr_wr_en` loads `sr_wr_data` into the status register, limited to the implemented bits. When `start` is high in the same cycle, the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Execute strobe, one cycle per operation |
| target | input | 2 | 00 general, 01 condition codes, 10 status register, 11 general |
| size | input | 2 | 00 byte, 01 word, 10/11 long |
| imm | input | 32 | Immediate operand |
| dst | input | 32 | Destination operand value |
| sr_wr_en | input | 1 | Direct status-register load enable |
| sr_wr_data | input | 16 | Direct status-register load value |
| result | output | 32 | Registered merged result |
| sr_out | output | 16 | Current status register |
| done | output | 1 | Completion strobe |
| trap | output | 1 | Privilege trap request pulse |

## Verification
Every result of this unit is due one clock edge after the edge that samples `start`. This covers the merged value, the flag update, the status-register change, and the `done` and `trap` pulses. The bench drives each operation on a falling edge. It then waits for exactly one rising edge and samples a nanosecond later. A further edge is then used to confirm that `done` and `trap` have dropped. Direct loads through `sr_wr_en` follow the same one-edge latency. Each load is read back before the next operation is issued.

// File: rtl/ori_pkg.sv
// Package: shared encodings and status-register layout for the immediate-OR unit.
// Assumes a 16-bit status register with trace at 15 and supervisor at 13.
package ori_pkg;
    typedef enum logic [1:0] {
        TGT_GEN  = 2'b00,
        TGT_CCR  = 2'b01,
        TGT_SR   = 2'b10,
        TGT_GEN2 = 2'b11
    } ori_target_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_LONG  = 2'b10,
        SZ_LONG2 = 2'b11
    } ori_size_e;

    localparam int SR_BIT_T = 15;
    localparam int SR_BIT_S = 13;
    localparam int CC_BIT_X = 4;
    localparam int CC_BIT_N = 3;
    localparam int CC_BIT_Z = 2;
    localparam int CC_BIT_V = 1;
    localparam int CC_BIT_C = 0;

    localparam logic [15:0] SR_IMPL_MASK = 16'hA71F;
    localparam logic [15:0] CC_MASK      = 16'h001F;
endpackage

// File: rtl/ori_gen_path.sv
// Module: size-aware OR of immediate and destination with sign/zero detection.
// Assumes DATA_W divisible by 4; byte is DATA_W/4 bits, word DATA_W/2.
module ori_gen_path #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] imm,
    input  logic [DATA_W-1:0] dst,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] res,
    output logic              neg,
    output logic              zero
);
    import ori_pkg::*;

    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    logic [DATA_W-1:0] merged;

    // Merge the whole width; size selection picks which part is kept.
    assign merged = imm | dst;

    // Select result slice and derive sign and zero at the chosen size.
    always_comb begin
        case (ori_size_e'(size))
            SZ_BYTE: begin
                res  = {dst[DATA_W-1:BYTE_W], merged[BYTE_W-1:0]};
                neg  = merged[BYTE_W-1];
                zero = (merged[BYTE_W-1:0] == '0);
            end
            SZ_WORD: begin
                res  = {dst[DATA_W-1:WORD_W], merged[WORD_W-1:0]};
                neg  = merged[WORD_W-1];
                zero = (merged[WORD_W-1:0] == '0);
            end
            default: begin
                res  = merged;
                neg  = merged[DATA_W-1];
                zero = (merged == '0);
            end
        endcase
    end
endmodule

// File: rtl/ori_sr_path.sv
// Module: next status-register value and privilege check for every target.
// Assumes sr_cur already has its unimplemented bits cleared.
module ori_sr_path #(
    parameter int SR_W = 16
) (
    input  logic [SR_W-1:0] sr_cur,
    input  logic [SR_W-1:0] imm,
    input  logic [1:0]      target,
    input  logic            gen_neg,
    input  logic            gen_zero,
    output logic [SR_W-1:0] sr_next,
    output logic            trap_req
);
    import ori_pkg::*;

    // Compute status update per target; raise trap for unprivileged SR write.
    always_comb begin
        sr_next  = sr_cur;
        trap_req = 1'b0;
        case (ori_target_e'(target))
            TGT_CCR: sr_next = sr_cur | (imm & CC_MASK);
            TGT_SR: begin
                if (sr_cur[SR_BIT_S]) begin
                    sr_next = sr_cur | (imm & SR_IMPL_MASK);
                end else begin
                    trap_req = 1'b1;
                end
            end
            default: begin
                sr_next[CC_BIT_N] = gen_neg;
                sr_next[CC_BIT_Z] = gen_zero;
                sr_next[CC_BIT_V] = 1'b0;
                sr_next[CC_BIT_C] = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ori_exec_unit.sv
// Module: top of the immediate-OR execute unit; holds the status register
// and registers result, done and trap one edge after start.
// Assumes start is a single-cycle strobe; start wins over a direct SR load.
module ori_exec_unit #(
    parameter int          DATA_W   = 32,
    parameter int          SR_W     = 16,
    parameter logic [15:0] SR_RESET = 16'h2700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        target,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] imm,
    input  logic [DATA_W-1:0] dst,
    input  logic              sr_wr_en,
    input  logic [SR_W-1:0]   sr_wr_data,
    output logic [DATA_W-1:0] result,
    output logic [SR_W-1:0]   sr_out,
    output logic              done,
    output logic              trap
);
    import ori_pkg::*;

    localparam int PAD_W = DATA_W - SR_W;

    logic [DATA_W-1:0] gen_res;
    logic              gen_neg;
    logic              gen_zero;
    logic [SR_W-1:0]   sr_q;
    logic [SR_W-1:0]   sr_next;
    logic              trap_req;
    logic [DATA_W-1:0] result_q;
    logic              done_q;
    logic              trap_q;
    logic              is_gen;

    ori_gen_path #(.DATA_W(DATA_W)) u_gen (
        .imm  (imm),
        .dst  (dst),
        .size (size),
        .res  (gen_res),
        .neg  (gen_neg),
        .zero (gen_zero)
    );

    ori_sr_path #(.SR_W(SR_W)) u_sr (
        .sr_cur   (sr_q),
        .imm      (imm[SR_W-1:0]),
        .target   (target),
        .gen_neg  (gen_neg),
        .gen_zero (gen_zero),
        .sr_next  (sr_next),
        .trap_req (trap_req)
    );

    // Decide whether the result port carries the operand or the status word.
    assign is_gen = (target == TGT_GEN) || (target == TGT_GEN2);

    // Register status, result and strobes; trap leaves all state untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q     <= SR_RESET[SR_W-1:0] & SR_IMPL_MASK[SR_W-1:0];
            result_q <= '0;
            done_q   <= 1'b0;
            trap_q   <= 1'b0;
        end else begin
            done_q <= start;
            trap_q <= start & trap_req;
            if (start) begin
                sr_q <= sr_next;
                if (!trap_req) begin
                    result_q <= is_gen ? gen_res : {{PAD_W{1'b0}}, sr_next};
                end
            end else if (sr_wr_en) begin
                sr_q <= sr_wr_data & SR_IMPL_MASK[SR_W-1:0];
            end
        end
    end

    assign result = result_q;
    assign sr_out = sr_q;
    assign done   = done_q;
    assign trap   = trap_q;
endmodule

// File: rtl/ori_exec_unit_chk.sv
// Module: protocol and state checks for ori_exec_unit, attached by bind.
// Assumes the port names of the top module.
module ori_exec_unit_chk #(
    parameter int SR_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [1:0]      target,
    input logic [SR_W-1:0] sr_out,
    input logic            done,
    input logic            trap
);
    localparam logic [SR_W-1:0] IMPL = 16'hA71F;

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start)); // R8
    AST_START_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done); // R8
    AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> done); // R7
    AST_TRAP_HOLDS_SR: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (sr_out == $past(sr_out))); // R7
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_out & ~IMPL) == '0); // R9
    AST_GEN_VC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && target[0] == target[1]) |=> (sr_out[1:0] == 2'b00)); // R4
    AST_GEN_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (start && target[0] == target[1]) |=>
            (sr_out[SR_W-1:4] == $past(sr_out[SR_W-1:4]))); // R4
    AST_CCR_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && target == 2'b01) |=>
            ((sr_out & $past(sr_out)) == $past(sr_out))
            && (sr_out[SR_W-1:5] == $past(sr_out[SR_W-1:5]))); // R5
endmodule

bind ori_exec_unit ori_exec_unit_chk #(.SR_W(SR_W)) u_chk (.*);

// File: tb/ori_exec_unit_test.sv
// Bench: directed scenarios for ori_exec_unit, one task per scenario.
module ori_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  target = 2'b00;
    logic [1:0]  size = 2'b00;
    logic [31:0] imm = '0;
    logic [31:0] dst = '0;
    logic        sr_wr_en = 1'b0;
    logic [15:0] sr_wr_data = '0;
    logic [31:0] result;
    logic [15:0] sr_out;
    logic        done;
    logic        trap;

    int n_tests = 0;
    int n_fail  = 0;

    ori_exec_unit uut (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Issue one operation; return after the edge that registers it, sampled 1 ns later.
    task automatic run_op(input logic [1:0] t, input logic [1:0] s,
                          input logic [31:0] i, input logic [31:0] d);
        @(negedge clk);
        target = t; size = s; imm = i; dst = d; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic load_sr(input logic [15:0] v);
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = v;
        @(posedge clk); #1;
        sr_wr_en = 1'b0;
    endtask

    // Reference model for a general operation.
    task automatic gen_case(input string tag, input logic [1:0] s,
                            input logic [31:0] i, input logic [31:0] d);
        logic [31:0] m, exp_res;
        logic        en, ez;
        logic [15:0] exp_sr, old_sr;
        old_sr = sr_out;
        m = i | d;
        case (s)
            2'b00: begin exp_res = {d[31:8], m[7:0]};   en = m[7];  ez = (m[7:0] == 0);  end
            2'b01: begin exp_res = {d[31:16], m[15:0]}; en = m[15]; ez = (m[15:0] == 0); end
            default: begin exp_res = m; en = m[31]; ez = (m == 0); end
        endcase
        exp_sr = {old_sr[15:4], en, ez, 2'b00};
        run_op(2'b00, s, i, d);
        check({tag, " R1 result"}, result, exp_res);
        check({tag, " R2 N"}, {31'b0, sr_out[3]}, {31'b0, en});
        check({tag, " R3 Z"}, {31'b0, sr_out[2]}, {31'b0, ez});
        check({tag, " R4 sr"}, {16'b0, sr_out}, {16'b0, exp_sr});
        check({tag, " R8 done"}, {31'b0, done}, 32'd1);
    endtask

    task automatic t_reset;
        check("R10 sr", {16'b0, sr_out}, 32'h2700);
        check("R10 result", result, 32'h0);
        check("R10 done", {31'b0, done}, 32'd0);
        check("R10 trap", {31'b0, trap}, 32'd0);
    endtask

    task automatic t_general;
        gen_case("byte neg", 2'b00, 32'h0000_0003, 32'h1234_5680);
        gen_case("byte zero", 2'b00, 32'h0000_0000, 32'hFFFF_FF00);
        gen_case("word neg", 2'b01, 32'h0000_8000, 32'h0001_0000);
        gen_case("word zero", 2'b01, 32'h0000_0000, 32'hABCD_0000);
        gen_case("long zero", 2'b10, 32'h0, 32'h0);
        gen_case("long neg", 2'b11, 32'h8000_0000, 32'h0000_0001);
        gen_case("long pos", 2'b10, 32'h0F00_0000, 32'h0000_00F0);
        @(posedge clk); #1;
        check("R8 done drops", {31'b0, done}, 32'd0);
    endtask

    task automatic t_ccr;
        run_op(2'b01, 2'b00, 32'h0000_00E3, 32'h0);
        check("R5 ccr set", {16'b0, sr_out}, 32'h2700 | 32'h03 | (32'h2700 & 0));
        check("R5 ccr result", result, {16'b0, sr_out});
        run_op(2'b01, 2'b00, 32'h0000_001C, 32'h0);
        check("R5 ccr all", {16'b0, sr_out}, 32'h271F);
        gen_case("R4 after ccr", 2'b00, 32'h1, 32'h0);
        check("R4 X kept", {31'b0, sr_out[4]}, 32'd1);
    endtask

    task automatic t_sr;
        logic [31:0] res_before;
        run_op(2'b10, 2'b01, 32'h0000_8000, 32'h0);
        check("R6 trace", {16'b0, sr_out}, 32'hA710);
        check("R6 no trap", {31'b0, trap}, 32'd0);
        check("R6 result", result, 32'h0000_A710);
        load_sr(16'h0000);
        check("R11 load", {16'b0, sr_out}, 32'h0);
        res_before = result;
        run_op(2'b10, 2'b01, 32'h0000_2000, 32'h0);
        check("R7 trap", {31'b0, trap}, 32'd1);
        check("R7 done", {31'b0, done}, 32'd1);
        check("R7 sr held", {16'b0, sr_out}, 32'h0);
        check("R7 result held", result, res_before);
        @(posedge clk); #1;
        check("R7 trap drops", {31'b0, trap}, 32'd0);
        load_sr(16'hFFFF);
        check("R9 unimpl", {16'b0, sr_out}, 32'hA71F);
        load_sr(16'h2000);
        // Load coinciding with start is ignored.
        @(negedge clk);
        target = 2'b01; size = 2'b00; imm = 32'h1; start = 1'b1;
        sr_wr_en = 1'b1; sr_wr_data = 16'h0000;
        @(posedge clk); #1;
        start = 1'b0; sr_wr_en = 1'b0;
        check("R11 start wins", {16'b0, sr_out}, 32'h2001);
        run_op(2'b10, 2'b01, 32'h0000_FFFF, 32'h0);
        check("R9 sr or masked", {16'b0, sr_out}, 32'hA71F);
    endtask

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_general();
        t_ccr();
        t_sr();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule